// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from a group of devices onto four shared interrupt lines. Every device drives four request pins. The block keeps the last accepted level of every pin. It acts only when a pin changes level: a rising pin adds one to the count of the line it maps to, and a falling pin takes one away. A line is high while its count is nonzero. Two devices can therefore share a line, and the line stays high until the last of them lets go.

Devices sit either directly on the root bus or behind a single bridge. A root device rotates its pin number by its own device number, modulo four. A device behind the bridge is rotated once by its own number, and the result is rotated again by the bridge's device number on the root bus. A per-device clear input models a device being reset or attached. It drops that device's stored levels to zero and withdraws their share of the counts. The outputs are registered.

Top module: `shared_irq_agg`

## Requirements
- R1: Each device has four request pins; pin p of root device d is bit 4*d+p of `root_req`, and pin p of bridged device j is bit 4*j+p of `leaf_req`.
- R2: Pin p of root device d is routed to line (p + d) mod 4.
- R3: Pin p of bridged device j is routed to line (((p + j) mod 4) + BRIDGE_SLOT) mod 4, with BRIDGE_SLOT = 5 by default.
- R4: A line is high exactly when at least one routed pin is held high; a line shared by several pins stays high until the last of them falls.
- R5: A pin held at an unchanged level is counted once, not once per cycle: after holding a pin high for several cycles, a single fall clears its line.
- R6: `irq_line` is registered and changes on the first rising clock edge after the request change, not before.
- R7: While bit d of a clear input is high at a clock edge, all four stored levels of that device become zero and leave the counts. If a pin is still high one cycle after the clear is released, it is counted again as a new rise.
- R8: Reset (`rst_n` low) zeroes all stored levels and counts and drives `irq_line` to 0. Pins that are high when reset is released are counted as rises.
- R9: No line count ever goes below zero or above the total number of pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_req | input | 4*ROOT_DEVS | Request levels of root-bus devices |
| leaf_req | input | 4*LEAF_DEVS | Request levels of devices behind the bridge |
| root_clr | input | ROOT_DEVS | Per-device clear, root-bus devices |
| leaf_clr | input | LEAF_DEVS | Per-device clear, bridged devices |
| irq_line | output | 4 | Shared interrupt lines |

## Verification
The bench uses the defaults: four root devices, four bridged devices and a bridge at slot 5. That gives eight devices, the full size asked for. Because slot 5 rotates bridged pins by one, the second hop is not the identity, so a mistake in the bridge rotation shows up on the lines. The vectors place a root pin and a bridged pin on the same line and then drop them one at a time. This exercises the counting across both bus levels, together with pin holding, clears and reset while inputs stay high.

// File: rtl/shared_irq_agg.sv
module shared_irq_agg #(
  parameter int ROOT_DEVS   = 4,
  parameter int LEAF_DEVS   = 4,
  parameter int BRIDGE_SLOT = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4*ROOT_DEVS-1:0] root_req,
  input  logic [4*LEAF_DEVS-1:0] leaf_req,
  input  logic [ROOT_DEVS-1:0]   root_clr,
  input  logic [LEAF_DEVS-1:0]   leaf_clr,
  output logic [3:0]             irq_line
);
  localparam int RB   = 4 * ROOT_DEVS;
  localparam int NSRC = RB + 4 * LEAF_DEVS;
  localparam int CW   = $clog2(NSRC + 1);

  logic [NSRC-1:0]        lvl_q, lvl_d, keep;
  logic [3:0][CW-1:0]     cnt_q, cnt_d;
  logic [3:0]             nz_d;

  function automatic logic [1:0] line_of(input int s);
    int j;
    if (s < RB) return 2'(((s % 4) + (s / 4)) % 4);
    j = (s - RB) / 4;
    return 2'(((((s % 4) + j) % 4) + BRIDGE_SLOT) % 4);
  endfunction

  always_comb begin
    for (int d = 0; d < ROOT_DEVS; d++) keep[4*d +: 4] = {4{~root_clr[d]}};
    for (int j = 0; j < LEAF_DEVS; j++) keep[RB + 4*j +: 4] = {4{~leaf_clr[j]}};
  end

  assign lvl_d = {leaf_req, root_req} & keep;

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      logic [CW-1:0] up, dn;
      up = '0;
      dn = '0;
      for (int s = 0; s < NSRC; s++) begin
        if (line_of(s) == 2'(l)) begin
          if (lvl_d[s] && !lvl_q[s]) up = up + CW'(1);
          if (!lvl_d[s] && lvl_q[s]) dn = dn + CW'(1);
        end
      end
      cnt_d[l] = cnt_q[l] + up - dn;
      nz_d[l]  = (cnt_d[l] != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= '0;
      cnt_q    <= '0;
      irq_line <= '0;
    end else begin
      lvl_q    <= lvl_d;
      cnt_q    <= cnt_d;
      irq_line <= nz_d;
    end
  end
endmodule

module shared_irq_agg_chk #(
  parameter int ROOT_DEVS   = 4,
  parameter int LEAF_DEVS   = 4,
  parameter int NSRC        = 32,
  parameter int CW          = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [4*ROOT_DEVS-1:0] root_req,
  input logic [4*LEAF_DEVS-1:0] leaf_req,
  input logic [ROOT_DEVS-1:0]   root_clr,
  input logic [LEAF_DEVS-1:0]   leaf_clr,
  input logic [3:0]             irq_line,
  input logic [NSRC-1:0]        lvl_q,
  input logic [3:0][CW-1:0]     cnt_q
);
  logic [31:0] total;
  logic [3:0]  nz;
  always_comb begin
    total = '0;
    for (int l = 0; l < 4; l++) begin
      total = total + 32'(cnt_q[l]);
      nz[l] = (cnt_q[l] != '0);
    end
  end

  // R4
  line_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq_line == nz);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt_q[0]) <= NSRC) && (32'(cnt_q[1]) <= NSRC) &&
    (32'(cnt_q[2]) <= NSRC) && (32'(cnt_q[3]) <= NSRC));

  // R5
  count_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total == 32'($countones(lvl_q)));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && root_req == $past(root_req) && leaf_req == $past(leaf_req) &&
     root_clr == '0 && leaf_clr == '0 && $past(root_clr) == '0 && $past(leaf_clr) == '0)
    |=> $stable(irq_line));
endmodule

bind shared_irq_agg shared_irq_agg_chk #(
  .ROOT_DEVS(ROOT_DEVS), .LEAF_DEVS(LEAF_DEVS), .NSRC(NSRC), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .root_req(root_req), .leaf_req(leaf_req),
  .root_clr(root_clr), .leaf_clr(leaf_clr), .irq_line(irq_line),
  .lvl_q(lvl_q), .cnt_q(cnt_q)
);

// File: tb/sim_shared_irq_agg.sv
module sim_shared_irq_agg;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] root_req = '0;
  logic [15:0] leaf_req = '0;
  logic [3:0]  root_clr = '0;
  logic [3:0]  leaf_clr = '0;
  logic [3:0]  irq_line;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  shared_irq_agg u0 (.clk(clk), .rst_n(rst_n), .root_req(root_req), .leaf_req(leaf_req),
                     .root_clr(root_clr), .leaf_clr(leaf_clr), .irq_line(irq_line));

  // {root_req, leaf_req, expected lines}; root d,p -> (p+d)%4, leaf j,p -> (p+j+1)%4
  localparam int NV = 14;
  localparam logic [35:0] VEC [NV] = '{
    {16'h0001, 16'h0000, 4'b0001},   // R2 d0p0 -> 0
    {16'h0020, 16'h0000, 4'b0100},   // R2 d1p1 -> 2
    {16'h8000, 16'h0000, 4'b0100},   // R2 d3p3 -> 2
    {16'h0000, 16'h0001, 4'b0010},   // R3 j0p0 -> 1
    {16'h0000, 16'h8000, 4'b1000},   // R3 j3p3 -> 3
    {16'h0048, 16'h0000, 4'b1000},   // R4 d0p3 and d1p2 share 3
    {16'h0040, 16'h0000, 4'b1000},   // R4 one left, still high
    {16'h0000, 16'h0000, 4'b0000},   // R4 last dropped
    {16'h0001, 16'h0200, 4'b0001},   // R4 root d0p0 and leaf j2p1 share 0
    {16'h0000, 16'h0200, 4'b0001},   // R4 leaf still holds 0
    {16'h0000, 16'h0000, 4'b0000},   // R4
    {16'h0000, 16'h0010, 4'b0100},   // R3 j1p0 -> 2
    {16'hFFFF, 16'hFFFF, 4'b1111},   // R1 every pin
    {16'h0000, 16'h0000, 4'b0000}    // R1
  };

  task automatic check(input logic [3:0] exp, input string tag);
    checks++;
    if (irq_line !== exp) begin
      fails++;
      $display("FAIL %s irq_line=%b expected=%b", tag, irq_line, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check(4'b0000, "R8 reset state");
    rst_n = 1;
    tick();
    check(4'b0000, "R8 idle after reset");

    for (int i = 0; i < NV; i++) begin
      root_req = VEC[i][35:20];
      leaf_req = VEC[i][19:4];
      tick();
      check(VEC[i][3:0], $sformatf("R2/R3/R4 vector %0d", i));
    end

    // R6: no change before the edge, change right after it
    root_req = 16'h0002;            // d0p1 -> 1
    @(negedge clk);
    check(4'b0000, "R6 before edge");
    tick();
    check(4'b0010, "R6 after edge");

    // R5: held high for many cycles, one fall clears
    repeat (6) tick();
    check(4'b0010, "R5 held");
    root_req = '0;
    tick();
    check(4'b0000, "R5 single fall clears");

    // R7: clears
    root_req = 16'h0081;            // d0p0 -> 0, d1p3 -> 0
    tick();
    check(4'b0001, "R7 setup");
    root_clr = 4'b0001;
    tick();
    check(4'b0001, "R7 one device cleared, other holds");
    root_clr = 4'b0011;
    tick();
    check(4'b0000, "R7 both cleared");
    root_clr = 4'b0000;
    tick();
    check(4'b0001, "R7 recounted after clear");
    root_req = '0;
    tick();
    check(4'b0000, "R7 released");
    leaf_req = 16'h0001;            // j0p0 -> 1
    tick();
    check(4'b0010, "R7 leaf setup");
    leaf_clr = 4'b0001;
    tick();
    check(4'b0000, "R7 leaf cleared");
    leaf_clr = 4'b0000;
    leaf_req = '0;
    tick();
    check(4'b0000, "R7 leaf dropped while stored zero");

    // R8: reset with inputs high
    root_req = 16'h0010;            // d1p0 -> 1
    tick();
    check(4'b0010, "R8 setup");
    rst_n = 0;
    tick();
    check(4'b0000, "R8 reset mid-run");
    rst_n = 1;
    tick();
    check(4'b0010, "R8 held pin counted after reset");
    root_req = '0;
    tick();
    check(4'b0000, "R9 count back to zero");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule